// File: doc/BRIEF.md
# Electrical Angle Interpolator with Phase Advance

This block turns the coarse rotor position of a three-phase motor into a finer electrical angle in degrees. The angle comes from four inputs: a sector number from 0 to 5, a rotation direction, the ticks counted since the last sector edge, and the tick length of the previous sector. Within the sector the position is linear: the tick count divided by the held period, scaled to 60 degrees, is added to the sector's base angle, or subtracted from it when the rotor turns in reverse.

An optional phase advance can be added on top. It is a function of the absolute duty command. The function is an 11-point table with evenly spaced breakpoints, and the block interpolates linearly between points using a Q31 fraction. The advance follows the sign of the direction and is added to the angle. The sum is then wrapped into 0..359 with floor-modulo semantics. The table entries, the first breakpoint and the breakpoint spacing are written through a small configuration port. Both divisions share one serial divider, and a one-cycle `valid` pulse marks new results. A zero control selector shuts the block down and clears both angle outputs.

Top module: `elec_angle_interp`

## Requirements
- R1: With `dir_fwd`=1 the base angle is `sector`×60, and `angle` = base + floor(60×`tick`/`period`).
- R2: With `dir_fwd`=0 the base angle is (`sector`+1)×60, and `angle` = base − floor(60×`tick`/`period`).
- R3: The interpolation term is the truncated unsigned quotient of 60×`tick` by `period`, so `tick` values past `period` extend the angle beyond one sector.
- R4: The advance is applied only when `adv_en`=1 and `speed` > `adv_thresh` (strictly); otherwise `angle_adv` equals `angle`.
- R5: The lookup input is |`duty`|. When that value is at or below the first breakpoint, the advance is table entry 0.
- R6: When (|`duty`| − first breakpoint) / spacing is 10 or more, the advance is table entry 10.
- R7: Otherwise, with i = that quotient and f = floor((remainder)×2^31 / spacing), the advance is entry[i] + floor((entry[i+1] − entry[i])×f / 2^31).
- R8: When applied, the advance is negated for reverse direction and added to `angle`; `angle_adv` is that sum reduced by floor modulo 360, always in 0..359.
- R9: While `ctrl_sel`=0, both angle outputs read 0 from the next cycle, `start` is ignored, a computation in progress is abandoned and no `valid` is produced.
- R10: `valid` is high for exactly one cycle per accepted `start`, and the angle outputs change only with `valid` or when they are cleared.
- R11: Configuration writes with `cfg_we`=1 store `cfg_data` in table entry `cfg_addr` for addresses 0..10, in the first breakpoint for address 11 and in the spacing for address 12. After reset the entries and the breakpoint are 0 and the spacing is 1.
- R12: After reset both angle outputs are 0 and `valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_sel | input | 2 | Control-type selector; zero disables the block |
| start | input | 1 | Launch a computation from the present inputs |
| sector | input | 3 | Sector position 0..5 |
| dir_fwd | input | 1 | 1 = forward (+1), 0 = reverse (−1) |
| tick | input | W | Working tick count within the sector |
| period | input | W | Held period of the last sector, nonzero |
| duty | input | W | Signed duty command |
| speed | input | W | Absolute speed |
| adv_en | input | 1 | Phase advance enable |
| adv_thresh | input | W | Speed above which advance is applied |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CAW | Configuration address (0..12) |
| cfg_data | input | W | Configuration write data |
| angle | output | OW | Interpolated electrical angle, signed degrees |
| angle_adv | output | OW | Advanced and wrapped angle, signed degrees |
| valid | output | 1 | One-cycle pulse when the outputs are updated |

## Verification
On every cycle the assertions check the following. `valid` never lasts two cycles. A zero selector clears the outputs on the next cycle. An advanced result always falls inside 0..359. The outputs move only with `valid` or when they are cleared. The divider remainder stays below its divisor. The values themselves cannot be checked that way. The sector base in each direction, the truncation of the tick ratio, the Q31 interpolation between table points, the clipping at both ends of the table, the strict speed threshold and the register address map can only be shown by the bench's directed scenarios, which compare results with values computed from the formulas.

// File: rtl/elec_angle_interp.sv
module elec_angle_interp #(
  parameter int W    = 16,
  parameter int NPTS = 11,
  parameter int CAW  = $clog2(NPTS + 2),
  parameter int OW   = W + 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           ctrl_sel,
  input  logic                 start,
  input  logic [2:0]           sector,
  input  logic                 dir_fwd,
  input  logic [W-1:0]         tick,
  input  logic [W-1:0]         period,
  input  logic signed [W-1:0]  duty,
  input  logic [W-1:0]         speed,
  input  logic                 adv_en,
  input  logic [W-1:0]         adv_thresh,
  input  logic                 cfg_we,
  input  logic [CAW-1:0]       cfg_addr,
  input  logic [W-1:0]         cfg_data,
  output logic signed [OW-1:0] angle,
  output logic signed [OW-1:0] angle_adv,
  output logic                 valid
);

  localparam int QW  = W + 31;
  localparam int NB1 = W + 6;
  localparam int CW  = $clog2(QW + 1);
  localparam int IW  = $clog2(NPTS);
  localparam logic signed [OW:0] FULL = (OW+1)'(360);

  typedef enum logic [1:0] {S_IDLE, S_DIV1, S_DIV2, S_FIN} st_t;
  st_t st;

  logic signed [W-1:0] tab [NPTS];
  logic [W-1:0]  bp0, spc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NPTS; k++) tab[k] <= '0;
      bp0 <= '0;
      spc <= W'(1);
    end else if (cfg_we) begin
      if (cfg_addr < CAW'(NPTS))        tab[cfg_addr] <= cfg_data;
      else if (cfg_addr == CAW'(NPTS))  bp0 <= cfg_data;
      else if (cfg_addr == CAW'(NPTS+1)) spc <= cfg_data;
    end
  end

  // shared serial divider state
  logic [W-1:0]  rem, dvs;
  logic [QW-1:0] dsr, quo;
  logic [CW-1:0] cnt;
  logic [W:0]    trial;
  logic          ge;

  assign trial = {rem, dsr[QW-1]};
  assign ge    = trial >= {1'b0, dvs};

  logic          dir_q, adv_q, below_q;
  logic [2:0]    base_q;
  logic [W-1:0]  uadj_q;
  logic signed [OW-1:0] ang_q;

  logic [W-1:0] uabs;
  assign uabs = duty[W-1] ? W'(-duty) : W'(duty);

  logic [OW-1:0]        q1x, b60;
  logic signed [OW-1:0] ang_nx;
  assign q1x    = OW'(quo[NB1-1:0]);
  assign b60    = OW'(base_q) * OW'(60);
  assign ang_nx = dir_q ? $signed(b60 + q1x) : $signed(b60 - q1x);

  logic [W-1:0]          qi;
  logic [30:0]           fr;
  logic [IW-1:0]         idx;
  logic signed [W:0]     dlt;
  logic signed [W+32:0]  prd;
  logic signed [W-1:0]   adv_val, adv_d;
  logic signed [OW:0]    sum, md, wrp;

  assign qi  = quo[QW-1:31];
  assign fr  = quo[30:0];
  assign idx = qi[IW-1:0];

  always_comb begin
    dlt = {tab[idx + IW'(1)][W-1], tab[idx + IW'(1)]} - {tab[idx][W-1], tab[idx]};
    prd = dlt * $signed({1'b0, fr});
    if (below_q)                  adv_val = tab[0];
    else if (qi >= W'(NPTS - 1))  adv_val = tab[NPTS-1];
    else                          adv_val = tab[idx] + W'(prd >>> 31);
  end

  assign adv_d = dir_q ? adv_val : -adv_val;
  assign sum   = {ang_q[OW-1], ang_q} + {{(OW+1-W){adv_d[W-1]}}, adv_d};
  assign md    = sum % FULL;
  assign wrp   = (md < 0) ? md + FULL : md;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; angle <= '0; angle_adv <= '0; valid <= 1'b0;
      rem <= '0; dvs <= W'(1); dsr <= '0; quo <= '0; cnt <= '0;
      dir_q <= 1'b1; adv_q <= 1'b0; below_q <= 1'b0; base_q <= '0;
      uadj_q <= '0; ang_q <= '0;
    end else if (ctrl_sel == 2'd0) begin
      st <= S_IDLE; angle <= '0; angle_adv <= '0; valid <= 1'b0;
    end else begin
      valid <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          dir_q   <= dir_fwd;
          base_q  <= dir_fwd ? sector : 3'(sector + 3'd1);
          adv_q   <= adv_en && (speed > adv_thresh);
          below_q <= uabs <= bp0;
          uadj_q  <= uabs - bp0;
          rem <= '0; quo <= '0; dvs <= period;
          dsr <= {NB1'(tick) * NB1'(60), (QW-NB1)'(0)};
          cnt <= CW'(NB1);
          st  <= S_DIV1;
        end
        S_DIV1, S_DIV2: begin
          if (cnt != '0) begin
            rem <= W'(ge ? trial - {1'b0, dvs} : trial);
            quo <= {quo[QW-2:0], ge};
            dsr <= {dsr[QW-2:0], 1'b0};
            cnt <= cnt - CW'(1);
          end else if (st == S_DIV1) begin
            ang_q <= ang_nx;
            if (adv_q && !below_q) begin
              rem <= '0; quo <= '0; dvs <= spc;
              dsr <= {uadj_q, 31'd0};
              cnt <= CW'(QW);
              st  <= S_DIV2;
            end else begin
              st <= S_FIN;
            end
          end else begin
            st <= S_FIN;
          end
        end
        S_FIN: begin
          angle     <= ang_q;
          angle_adv <= adv_q ? OW'(wrp) : ang_q;
          valid     <= 1'b1;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r10_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  a_r9_deselect_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_sel == 2'd0) |=> (angle == '0 && angle_adv == '0 && !valid));

  a_r8_wrap_range: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && adv_q) |-> (angle_adv >= 0 && angle_adv < 360));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(angle) |-> (valid || angle == '0));

  a_r3_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DIV1 || st == S_DIV2) |-> (rem < dvs));

endmodule

// File: tb/test_elec_angle_interp.sv
module test_elec_angle_interp;
  localparam int W = 16, NPTS = 11, CAW = 4, OW = 24;

  logic clk = 0, rst_n = 0;
  logic [1:0] ctrl_sel = 2'd1;
  logic start = 0, dir_fwd = 1, adv_en = 0, cfg_we = 0;
  logic [2:0] sector = 0;
  logic [W-1:0] tick = 0, period = 1, speed = 0, adv_thresh = 0, cfg_data = 0;
  logic signed [W-1:0] duty = 0;
  logic [CAW-1:0] cfg_addr = 0;
  logic signed [OW-1:0] angle, angle_adv;
  logic valid;

  int checks = 0, errors = 0;
  int tbl [NPTS];
  int bp = 0, sp = 1;

  always #4 clk = ~clk;

  elec_angle_interp #(.W(W), .NPTS(NPTS), .CAW(CAW), .OW(OW)) i_elec_angle_interp (
    .clk, .rst_n, .ctrl_sel, .start, .sector, .dir_fwd, .tick, .period, .duty,
    .speed, .adv_en, .adv_thresh, .cfg_we, .cfg_addr, .cfg_data,
    .angle, .angle_adv, .valid);

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint model_ang(int sec, bit fwd, longint tk, longint per);
    longint q = (60 * tk) / per;
    return fwd ? sec * 60 + q : (sec + 1) * 60 - q;
  endfunction

  function automatic longint model_adv(longint ang, bit fwd, longint dt, bit en,
                                       longint spd, longint thr);
    longint u, ua, qi, r, f, d, a, s, m;
    if (!(en && spd > thr)) return ang;
    u = dt < 0 ? -dt : dt;
    if (u <= bp) a = tbl[0];
    else begin
      ua = u - bp; qi = ua / sp;
      if (qi >= NPTS - 1) a = tbl[NPTS-1];
      else begin
        r = ua - qi * sp; f = (r <<< 31) / sp;
        d = tbl[qi+1] - tbl[qi];
        a = tbl[qi] + ((d * f) >>> 31);
      end
    end
    s = ang + (fwd ? a : -a);
    m = s % 360;
    if (m < 0) m += 360;
    return m;
  endfunction

  task automatic cfg_write(int addr, int data);
    @(negedge clk);
    cfg_we = 1; cfg_addr = CAW'(addr); cfg_data = W'(data);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic run(string req, int sec, bit fwd, int tk, int per, int dt,
                     bit en, int spd, int thr);
    int n = 0;
    longint ea, eb;
    @(negedge clk);
    sector = 3'(sec); dir_fwd = fwd; tick = W'(tk); period = W'(per);
    duty = W'(dt); adv_en = en; speed = W'(spd); adv_thresh = W'(thr);
    start = 1;
    @(negedge clk);
    start = 0;
    while (!valid && n < 400) begin @(negedge clk); n++; end
    check({req, " valid seen"}, valid, 1);
    ea = model_ang(sec, fwd, tk, per);
    eb = model_adv(ea, fwd, dt, en, spd, thr);
    check({req, " angle"}, angle, ea);
    check({req, " angle_adv"}, angle_adv, eb);
    @(negedge clk);
    check("R10 valid one cycle", valid, 0);
    repeat (3) @(negedge clk);
    check("R10 angle held", angle, ea);
  endtask

  task automatic t_reset;
    check("R12 reset angle", angle, 0);
    check("R12 reset angle_adv", angle_adv, 0);
    check("R12 reset valid", valid, 0);
    // R11 defaults: zero table, bp 0, spacing 1 -> advance 0, result wrapped
    run("R11 default config", 5, 1, 150, 100, 500, 1, 10, 0);
  endtask

  task automatic t_forward;
    run("R1 fwd mid", 2, 1, 50, 100, 0, 0, 0, 0);
    run("R1 fwd start", 0, 1, 0, 77, 0, 0, 0, 0);
    run("R3 truncation", 3, 1, 1, 7, 0, 0, 0, 0);
    run("R3 tick over period", 4, 1, 250, 100, 0, 0, 0, 0);
  endtask

  task automatic t_reverse;
    run("R2 rev mid", 2, 0, 50, 100, 0, 0, 0, 0);
    run("R2 rev sector5", 5, 0, 13, 40, 0, 0, 0, 0);
    run("R2 rev over", 0, 0, 300, 100, 0, 0, 0, 0);
  endtask

  task automatic t_config;
    int vals [NPTS] = '{0, 4, 9, 15, 18, 22, 30, 31, 35, 40, 48};
    for (int k = 0; k < NPTS; k++) begin tbl[k] = vals[k]; cfg_write(k, vals[k]); end
    bp = 200; cfg_write(11, 200);   // R11 first breakpoint
    sp = 300; cfg_write(12, 300);   // R11 spacing
  endtask

  task automatic t_interp;
    run("R7 interp mid", 1, 1, 30, 90, 1234, 1, 500, 100);
    run("R7 interp first interval", 3, 1, 10, 60, 201, 1, 500, 100);
    run("R7 interp last interval", 2, 1, 5, 100, 3199, 1, 500, 100);
    run("R5 negative duty", 2, 1, 40, 80, -2050, 1, 500, 100);
  endtask

  task automatic t_clip;
    run("R5 at first breakpoint", 1, 1, 20, 100, 200, 1, 500, 100);
    run("R5 below first breakpoint", 1, 0, 20, 100, -50, 1, 500, 100);
    run("R6 at last interval", 2, 1, 20, 100, 3200, 1, 500, 100);
    run("R6 most negative duty", 2, 0, 20, 100, -32768, 1, 500, 100);
  endtask

  task automatic t_threshold;
    run("R4 speed equals threshold", 3, 1, 20, 100, 1234, 1, 100, 100);
    run("R4 speed above threshold", 3, 1, 20, 100, 1234, 1, 101, 100);
    run("R4 enable low", 3, 1, 20, 100, 1234, 0, 900, 100);
  endtask

  task automatic t_wrap;
    run("R8 forward over 360", 5, 1, 99, 100, 3500, 1, 500, 100);
    run("R8 reverse below zero", 0, 0, 59, 60, 3500, 1, 500, 100);
    run("R8 reverse large tick", 1, 0, 500, 100, 1500, 1, 500, 100);
  endtask

  task automatic t_deselect;
    int seen = 0;
    @(negedge clk);
    ctrl_sel = 2'd0;
    @(negedge clk);
    check("R9 cleared angle", angle, 0);
    check("R9 cleared angle_adv", angle_adv, 0);
    start = 1; sector = 3'd4; tick = 16'd10; period = 16'd20;
    @(negedge clk);
    start = 0;
    repeat (150) begin @(negedge clk); if (valid) seen++; end
    check("R9 start ignored", seen, 0);
    check("R9 angle stays zero", angle, 0);
    ctrl_sel = 2'd3;
    @(negedge clk);
    start = 1; adv_en = 0;
    @(negedge clk);
    start = 0;
    repeat (10) @(negedge clk);
    ctrl_sel = 2'd0;
    seen = 0;
    repeat (150) begin @(negedge clk); if (valid) seen++; end
    check("R9 abort no valid", seen, 0);
    check("R9 abort angle_adv zero", angle_adv, 0);
    ctrl_sel = 2'd2;
    run("R9 recovery after reselect", 4, 1, 10, 20, 0, 0, 0, 0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < NPTS; k++) tbl[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_forward();
    t_reverse();
    t_config();
    t_interp();
    t_clip();
    t_threshold();
    t_wrap();
    t_deselect();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule